// File: doc/BRIEF.md
# Character Glyph Row Fetcher

This block serves a character-cell text display. For every 8-pixel character slot it takes the character code fetched from screen memory and the scanline index inside the cell. From these it forms the address of one glyph byte, reads that byte from one of two sources, and shifts the byte out as eight pixels. The two sources are a fixed font ROM holding 256 glyphs and a user-loadable region in the upper half of a 4K video RAM holding 128 glyphs.

The top bit of the code selects the drawing rule. A display mode flag, latched once per band of character rows, decides what that bit means. With the flag set, codes 128 to 255 draw user glyphs from video RAM. With the flag clear, the same codes draw the ROM glyph with every pixel inverted. Codes 0 to 127 always draw the ROM glyph unchanged. Each glyph takes 16 bytes, but only rows 0 to 9 of a cell are visible.

The memory answers a read with a registered one-cycle latency. The block registers the address and source select, captures the returned byte two clocks after the fetch, and holds it in a staging register until the current byte has been shifted out.

Top module: `glyph_row_fetch`

## Requirements
- R1: While reset is asserted and right after it, `pixel_out`, `mem_addr` and `mem_src_ram` are all 0.
- R2: A fetch with the effective mode set and code bit 7 = 1 drives `mem_src_ram` = 1 and `mem_addr` = 0x800 + {code[6:0], row[3:0]}. It displays the video RAM byte at that address unchanged.
- R3: Any other fetch drives `mem_src_ram` = 0 and `mem_addr` = {code[7:0], row[3:0]}, which is a font ROM address.
- R4: With the effective mode clear and code bit 7 = 1, the displayed byte is the bitwise inverse of the ROM byte.
- R5: With code bit 7 = 0, the displayed byte is the ROM byte unchanged in either mode.
- R6: The mode flag is taken from `mode_in` only in a cycle where `band_start` = 1. Changes of `mode_in` at other times have no effect. A fetch in the same cycle as `band_start` already uses the new `mode_in`.
- R7: For row indices 10 to 15 the displayed byte is all background (0), whatever the glyph data and mode.
- R8: A fetch happens at the first pixel enable of each 8-pixel slot, sampling `char_code` and `row_idx` in that cycle. `mem_addr` and `mem_src_ram` change on the clock after a fetch and hold at all other times.
- R9: Pixels leave most significant bit first, one per `pix_en`. The byte fetched in slot k is shown during slot k+1, and `pixel_out` holds while `pix_en` = 0.
- R10: The first slot after reset shows background, because no byte has been fetched for it yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel per pulse |
| band_start | input | 1 | Start-of-character-row strobe, latches the mode |
| mode_in | input | 1 | Requested mode: 1 = user glyphs for codes with bit 7 set |
| char_code | input | 8 | Character code from screen memory |
| row_idx | input | 4 | Scanline index inside the cell |
| mem_rdata | input | 8 | Glyph byte returned one clock after the address |
| mem_addr | output | 12 | Glyph byte address |
| mem_src_ram | output | 1 | 1 = address targets video RAM, 0 = font ROM |
| pixel_out | output | 1 | Serial pixel stream |

## Verification
A band strobe can fall in the same cycle as a fetch. This cycle sets which mode the fetched byte obeys. The bench waits until its model says the slot counter is at its first pixel, then pulses `band_start` with a new `mode_in` value. It also pulses the strobe in the middle of a slot, and it toggles `mode_in` with no strobe at all. The cycle-level model predicts the address, the source and all eight pixels of the following slot from the new mode in the first case and from the old mode in the others. Every clock is compared against it.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    typedef enum logic {
        SRC_ROM = 1'b0,
        SRC_RAM = 1'b1
    } glyph_src_e;

    typedef struct packed {
        logic invert;
        logic blank;
    } glyph_attr_t;

endpackage

// File: rtl/glyph_req_stage.sv
module glyph_req_stage
    import glyph_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int ROW_W    = 4,
    parameter int VIS_ROWS = 10,
    parameter int RAM_BASE = 2048,
    localparam int ADDR_W  = CODE_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic              band_start,
    input  logic              mode_in,
    input  logic [CODE_W-1:0] char_code,
    input  logic [ROW_W-1:0]  row_idx,
    output logic [ADDR_W-1:0] addr,
    output glyph_src_e        src,
    output glyph_attr_t       attr,
    output logic              req_valid,
    output logic              mode
);

    localparam logic [ADDR_W-1:0] RAM_BASE_A = ADDR_W'(RAM_BASE);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        glyph_src_e        src;
        glyph_attr_t       attr;
        logic              valid;
        logic              mode;
    } req_t;

    req_t s_d, s_q;

    logic              eff_mode;
    logic              top_bit;
    logic [ADDR_W-1:0] rom_addr;
    logic [ADDR_W-1:0] ram_addr;

    always_comb begin
        // a strobe in the fetch cycle already steers that fetch
        eff_mode = band_start ? mode_in : s_q.mode;
        top_bit  = char_code[CODE_W-1];
        rom_addr = {char_code, row_idx};
        ram_addr = RAM_BASE_A | ADDR_W'({char_code[CODE_W-2:0], row_idx});

        s_d       = s_q;
        s_d.valid = fetch;
        if (band_start) begin
            s_d.mode = mode_in;
        end
        if (fetch) begin
            if (eff_mode && top_bit) begin
                s_d.addr = ram_addr;
                s_d.src  = SRC_RAM;
            end else begin
                s_d.addr = rom_addr;
                s_d.src  = SRC_ROM;
            end
            s_d.attr.invert = !eff_mode && top_bit;
            s_d.attr.blank  = int'(row_idx) >= VIS_ROWS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr      = s_q.addr;
    assign src       = s_q.src;
    assign attr      = s_q.attr;
    assign req_valid = s_q.valid;
    assign mode      = s_q.mode;

endmodule

// File: rtl/glyph_data_stage.sv
module glyph_data_stage
    import glyph_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  glyph_attr_t      req_attr,
    input  logic [PIX_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output glyph_attr_t      rsp_attr,
    output logic [PIX_W-1:0] next_byte
);

    typedef struct packed {
        logic             rsp_valid;
        glyph_attr_t      rsp_attr;
        logic [PIX_W-1:0] byte_val;
    } data_t;

    data_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        // the memory registers its output one clock after the address
        s_d.rsp_valid = req_valid;
        if (req_valid) begin
            s_d.rsp_attr = req_attr;
        end
        if (s_q.rsp_valid) begin
            if (s_q.rsp_attr.blank) begin
                s_d.byte_val = '0;
            end else if (s_q.rsp_attr.invert) begin
                s_d.byte_val = ~mem_rdata;
            end else begin
                s_d.byte_val = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_attr  = s_q.rsp_attr;
    assign next_byte = s_q.byte_val;

endmodule

// File: rtl/glyph_shifter.sv
module glyph_shifter #(
    parameter int PIX_W     = 8,
    parameter bit MSB_FIRST = 1'b1,
    localparam int CNT_W    = $clog2(PIX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [PIX_W-1:0] load_byte,
    output logic             fetch,
    output logic             pixel
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PIX_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PIX_W-1:0] shift;
    } shf_t;

    shf_t s_d, s_q;
    logic [PIX_W-1:0] shifted;

    generate
        if (MSB_FIRST) begin : g_msb_first
            assign shifted = {s_q.shift[PIX_W-2:0], 1'b0};
            assign pixel   = s_q.shift[PIX_W-1];
        end else begin : g_lsb_first
            assign shifted = {1'b0, s_q.shift[PIX_W-1:1]};
            assign pixel   = s_q.shift[0];
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (pix_en) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt   = '0;
                s_d.shift = load_byte;
            end else begin
                s_d.cnt   = s_q.cnt + 1'b1;
                s_d.shift = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch = pix_en && (s_q.cnt == '0);

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
    import glyph_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int ROW_W     = 4,
    parameter int PIX_W     = 8,
    parameter int VIS_ROWS  = 10,
    parameter int RAM_BASE  = 2048,
    parameter bit MSB_FIRST = 1'b1,
    localparam int ADDR_W   = CODE_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              band_start,
    input  logic              mode_in,
    input  logic [CODE_W-1:0] char_code,
    input  logic [ROW_W-1:0]  row_idx,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_src_ram,
    output logic              pixel_out
);

    logic         fetch;
    glyph_src_e   src;
    glyph_attr_t  req_attr;
    logic         req_valid;
    logic         mode_q;
    logic         rsp_valid;
    glyph_attr_t  rsp_attr;
    logic [PIX_W-1:0] next_byte;

    glyph_req_stage #(
        .CODE_W   (CODE_W),
        .ROW_W    (ROW_W),
        .VIS_ROWS (VIS_ROWS),
        .RAM_BASE (RAM_BASE)
    ) req_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch      (fetch),
        .band_start (band_start),
        .mode_in    (mode_in),
        .char_code  (char_code),
        .row_idx    (row_idx),
        .addr       (mem_addr),
        .src        (src),
        .attr       (req_attr),
        .req_valid  (req_valid),
        .mode       (mode_q)
    );

    glyph_data_stage #(
        .PIX_W (PIX_W)
    ) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_attr  (req_attr),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_attr  (rsp_attr),
        .next_byte (next_byte)
    );

    glyph_shifter #(
        .PIX_W     (PIX_W),
        .MSB_FIRST (MSB_FIRST)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .load_byte (next_byte),
        .fetch     (fetch),
        .pixel     (pixel_out)
    );

    assign mem_src_ram = (src == SRC_RAM);

endmodule

// File: rtl/glyph_row_fetch_chk.sv
module glyph_row_fetch_chk #(
    parameter int CODE_W   = 8,
    parameter int ROW_W    = 4,
    parameter int PIX_W    = 8,
    parameter int RAM_BASE = 2048,
    localparam int ADDR_W  = CODE_W + ROW_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              band_start,
    input logic              mode_in,
    input logic [CODE_W-1:0] char_code,
    input logic [ROW_W-1:0]  row_idx,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_src_ram,
    input logic              pixel_out,
    input logic              fetch,
    input logic              mode_q,
    input logic              rsp_valid,
    input logic              rsp_blank,
    input logic [PIX_W-1:0]  next_byte
);

    // R2: a video RAM access never leaves the glyph region
    p_ram_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_src_ram |-> (int'(mem_addr) >= RAM_BASE));

    // R3: codes below 128 always address the ROM with {code,row}
    p_rom_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !char_code[CODE_W-1]) |=>
            (!mem_src_ram && mem_addr == {$past(char_code), $past(row_idx)}));

    // R6: a strobe with mode 1 in the fetch cycle steers that fetch to RAM
    p_same_cycle_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && band_start && mode_in && char_code[CODE_W-1]) |=> mem_src_ram);

    // R6: the latched mode only moves on a strobe
    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !band_start |=> $stable(mode_q));

    // R7: blanked rows land in the staging register as background
    p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_blank) |=> (next_byte == '0));

    // R8: the address only moves on the clock after a fetch
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> ($stable(mem_addr) && $stable(mem_src_ram)));

    // R8: no two fetches in back-to-back cycles
    p_one_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> !fetch);

    // R9: the pixel stream holds without a pixel enable
    p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pixel_out));

endmodule

bind glyph_row_fetch glyph_row_fetch_chk #(
    .CODE_W   (CODE_W),
    .ROW_W    (ROW_W),
    .PIX_W    (PIX_W),
    .RAM_BASE (RAM_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .band_start  (band_start),
    .mode_in     (mode_in),
    .char_code   (char_code),
    .row_idx     (row_idx),
    .mem_addr    (mem_addr),
    .mem_src_ram (mem_src_ram),
    .pixel_out   (pixel_out),
    .fetch       (fetch),
    .mode_q      (mode_q),
    .rsp_valid   (rsp_valid),
    .rsp_blank   (rsp_attr.blank),
    .next_byte   (next_byte)
);

// File: tb/glyph_row_fetch_tb.sv
module glyph_row_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        band_start = 1'b0;
    logic        mode_in = 1'b0;
    logic [7:0]  char_code = '0;
    logic [3:0]  row_idx = '0;
    logic [7:0]  mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_src_ram;
    logic        pixel_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    glyph_row_fetch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en      (pix_en),
        .band_start  (band_start),
        .mode_in     (mode_in),
        .char_code   (char_code),
        .row_idx     (row_idx),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_src_ram (mem_src_ram),
        .pixel_out   (pixel_out)
    );

    // glyph memories: font ROM and 4K video RAM, registered read
    logic [7:0] rom_m [4096];
    logic [7:0] ram_m [4096];

    initial begin
        for (int i = 0; i < 4096; i++) begin
            rom_m[i] = 8'(i * 37 + (i >> 4) * 11 + 3);
            ram_m[i] = 8'((i * 53) ^ 8'h5A);
        end
    end

    always @(posedge clk) begin
        mem_rdata <= mem_src_ram ? ram_m[mem_addr] : rom_m[mem_addr];
    end

    // behavioural reference state
    int         m_cnt = 0;
    bit         m_mode = 0;
    logic [7:0] m_shift = '0;
    logic [11:0] m_addr = '0;
    bit         m_src = 0;
    string      cur_tag = "R10";
    string      addr_tag = "R1";
    string      phase = "R1";
    logic [7:0] q_byte[$];
    string      q_tag[$];

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit pe, input bit bs, input bit md,
                        input logic [7:0] code, input logic [3:0] row);
        bit eff;
        bit use_ram;
        logic [7:0] b;
        string t;
        pix_en     = pe;
        band_start = bs;
        mode_in    = md;
        char_code  = code;
        row_idx    = row;
        eff = bs ? md : m_mode;
        addr_tag = "R8";
        if (pe) begin
            if (m_cnt == 0) begin
                use_ram = eff && code[7];
                m_src   = use_ram;
                m_addr  = use_ram ? (12'h800 | {1'b0, code[6:0], row}) : {code, row};
                b = use_ram ? ram_m[m_addr] : rom_m[m_addr];
                t = use_ram ? "R2" : (code[7] ? "R4" : "R5");
                if (!eff && code[7]) b = ~b;
                if (row >= 4'd10) begin
                    b = '0;
                    t = "R7";
                end
                addr_tag = use_ram ? "R2" : "R3";
                q_byte.push_back(b);
                q_tag.push_back(t);
            end
            if (m_cnt == 7) begin
                if (q_byte.size() > 0) begin
                    m_shift = q_byte.pop_front();
                    cur_tag = q_tag.pop_front();
                end else begin
                    m_shift = '0;
                    cur_tag = "R10";
                end
            end else begin
                m_shift = {m_shift[6:0], 1'b0};
            end
            m_cnt = (m_cnt + 1) % 8;
        end
        if (bs) m_mode = md;
        @(negedge clk);
        // R9: pixel sequence (MSB first) judged every clock
        check({phase, "/", cur_tag, "/R9 pixel"}, int'(pixel_out), int'(m_shift[7]));
        check({phase, "/", addr_tag, " addr"}, int'(mem_addr), int'(m_addr));
        check({phase, "/", addr_tag, " src"}, int'(mem_src_ram), int'(m_src));
    endtask

    task automatic run_phase(input string tag, input int cycles,
                             input logic [7:0] or_mask, input logic [7:0] and_mask,
                             input int row_lo, input int row_span,
                             input int pe_period, input bit md, input bit strobe);
        phase = tag;
        for (int k = 0; k < cycles; k++) begin
            logic [7:0] c;
            logic [3:0] r;
            c = (8'(k * 29 + 7) & and_mask) | or_mask;
            r = 4'(row_lo + (k % row_span));
            step((k % pe_period) == 0, strobe && (k == 0), md, c, r);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pixel", int'(pixel_out), 0);
        check("R1 addr", int'(mem_addr), 0);
        check("R1 src", int'(mem_src_ram), 0);
        rst_n = 1'b1;

        // R10 then R5: mode clear, plain codes, pixel enable every clock
        run_phase("R5", 160, 8'h00, 8'h7F, 0, 10, 1, 1'b0, 1'b1);
        // R4: mode clear, top bit set, inverted ROM glyph
        run_phase("R4", 160, 8'h80, 8'h7F, 0, 10, 1, 1'b0, 1'b1);
        // R2: mode set, mixed codes
        run_phase("R2", 240, 8'h00, 8'hFF, 0, 10, 1, 1'b1, 1'b1);
        // R6: mode_in changes without a strobe have no effect
        run_phase("R6", 80, 8'h80, 8'h7F, 0, 10, 1, 1'b0, 1'b0);
        run_phase("R6", 80, 8'h80, 8'h7F, 0, 10, 1, 1'b1, 1'b0);
        // R6: strobe in the very cycle of a fetch, new mode must apply
        phase = "R6";
        for (int n = 0; n < 4; n++) begin
            while (m_cnt != 0) step(1'b1, 1'b0, 1'b0, 8'hC3, 4'd2);
            step(1'b1, 1'b1, n[0], 8'h80 + 8'(n * 9), 4'(n + 1));
            for (int j = 0; j < 20; j++) step(1'b1, 1'b0, ~n[0], 8'h91, 4'(j % 10));
        end
        // R6: strobe in the middle of a slot
        while (m_cnt != 3) step(1'b1, 1'b0, 1'b1, 8'hA0, 4'd4);
        step(1'b1, 1'b1, 1'b0, 8'hA5, 4'd5);
        run_phase("R6", 40, 8'h80, 8'h7F, 0, 10, 1, 1'b1, 1'b0);
        // R7: hidden rows in both modes
        run_phase("R7", 120, 8'h00, 8'hFF, 10, 6, 1, 1'b1, 1'b1);
        run_phase("R7", 120, 8'h00, 8'hFF, 10, 6, 1, 1'b0, 1'b1);
        // R8/R9: sparse pixel enables, inputs changing every clock
        run_phase("R8", 300, 8'h00, 8'hFF, 0, 16, 3, 1'b1, 1'b1);
        run_phase("R9", 300, 8'h00, 8'hFF, 0, 10, 5, 1'b0, 1'b1);
        run_phase("R9", 24, 8'h00, 8'hFF, 0, 10, 1, 1'b0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule